// File: doc/BRIEF.md
# Program Counter and Branch Sequencer

This block owns the fetch address of a 32-bit processor. In every clock cycle it receives the 8-bit opcode of the instruction that sits at the current address. It also receives the 24-bit signed relative offset field of that instruction and the nine condition flags produced by earlier arithmetic. From these it registers the address of the next fetch. It covers five cases:

- plain sequential advance;
- a no-operation;
- a sticky halt;
- unconditional jumps and conditional jumps;
- a subroutine call.

For a call, the block also hands the stack logic a one-cycle push request together with the return address.

The opcode carries a 3-bit class field and a 5-bit operation field. Only the system class and the flow class are acted on. Every other class simply moves the address forward by one instruction word. A halt freezes the address until the synchronous reset is applied. While the block is halted it takes no further action.

Top module: `flow_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes 0, `halted` becomes 0 and `ret_push` becomes 0.
- R2: The following opcodes move `pc_q` forward by STEP (4) at the next edge, ignoring `offset` and `flags`: opcodes whose class field `opcode[7:5]` is neither 3'b000 (system) nor 3'b110 (flow); system operation 0 (no-operation); system operations 2..31; and flow operations 11..31.
- R3: Flow operation 0 (opcode 8'hC0) is an unconditional jump: the next `pc_q` is `pc_q` plus the offset.
- R4: Every jump target is `pc_q` plus `offset` sign-extended from bit 23 to 32 bits, taken modulo 2^32, so negative offsets go backward and may wrap past zero.
- R5: Flow operations 1..9 are conditional jumps. Operation k tests `flags[k-1]`, where the flag bits are: 0 zero, 1 equal-to-one, 2 not-zero, 3 carry clear, 4 carry set, 5 less-than, 6 greater-than, 7 equal, 8 not-equal. The jump is taken only when that bit is 1; otherwise `pc_q` advances by STEP.
- R6: A conditional jump ignores every flag bit except the one it tests.
- R7: System operation 1 (opcode 8'h01) leaves `pc_q` at its current value and sets `halted` at the next edge.
- R8: While `halted` is 1, every opcode is ignored: `pc_q` stays constant, `ret_push` stays 0, and only R1 clears the state.
- R9: Flow operation 10 (opcode 8'hCA) is an unconditional call. At the next edge `pc_q` takes the jump target, `ret_push` is 1 for that one cycle, and `ret_addr` equals the call's own address plus STEP.
- R10: `ret_push` is 0 in any cycle that does not directly follow a call accepted while the block was not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Opcode of the instruction at `pc_q` |
| offset | input | 24 | Signed relative jump offset |
| flags | input | 9 | Condition flags, bit order as in R5 |
| pc_q | output | 32 | Registered fetch address |
| halted | output | 1 | Sticky halt indication |
| ret_push | output | 1 | One-cycle push request for the return address |
| ret_addr | output | 32 | Return address that goes with `ret_push` |

## Verification
The hardest states to reach from the ports are those after a halt has been taken. To prove that a jump or a call is ignored there, the stimulus first drives the halt opcode. It then presents a jump with a large offset, followed by a call. At each step it confirms that the address, the halt indication and the push request are all unchanged.

Wrap-around of the jump target is reached in a similar way. A reset first puts the address at zero, and a backward jump then takes it to the top of the address space. Two further advances then carry the address back through zero.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
  localparam int CLS_W = 3;
  localparam int SUB_W = 5;
  localparam logic [CLS_W-1:0] CLS_SYSTEM = 3'b000;
  localparam logic [CLS_W-1:0] CLS_FLOW   = 3'b110;

  typedef enum logic [2:0] {
    ACT_STEP,
    ACT_JUMP,
    ACT_COND,
    ACT_CALL,
    ACT_HALT
  } act_t;
endpackage

// File: rtl/fpu_op_decode.sv
module fpu_op_decode
  import fpu_pkg::*;
#(
  parameter int NUM_COND = 9,
  parameter int CSEL_W   = $clog2(NUM_COND)
) (
  input  logic [CLS_W+SUB_W-1:0] opcode,
  output act_t                   act,
  output logic [CSEL_W-1:0]      cond_sel
);
  localparam logic [SUB_W-1:0] SUB_NOP   = SUB_W'(0);
  localparam logic [SUB_W-1:0] SUB_HALT  = SUB_W'(1);
  localparam logic [SUB_W-1:0] SUB_JUMP  = SUB_W'(0);
  localparam logic [SUB_W-1:0] LAST_COND = SUB_W'(NUM_COND);
  localparam logic [SUB_W-1:0] SUB_CALL  = SUB_W'(NUM_COND + 1);

  logic [CLS_W-1:0] cls;
  logic [SUB_W-1:0] sub;

  assign cls      = opcode[CLS_W+SUB_W-1:SUB_W];
  assign sub      = opcode[SUB_W-1:0];
  assign cond_sel = CSEL_W'(sub - SUB_W'(1));

  always_comb begin
    act = ACT_STEP;
    if (cls == CLS_SYSTEM) begin
      if (sub == SUB_HALT) act = ACT_HALT;
      else if (sub == SUB_NOP) act = ACT_STEP;
    end else if (cls == CLS_FLOW) begin
      if (sub == SUB_JUMP) act = ACT_JUMP;
      else if (sub <= LAST_COND) act = ACT_COND;
      else if (sub == SUB_CALL) act = ACT_CALL;
    end
  end
endmodule

// File: rtl/fpu_cond_select.sv
module fpu_cond_select #(
  parameter int NUM_COND = 9,
  parameter int CSEL_W   = $clog2(NUM_COND)
) (
  input  logic [NUM_COND-1:0] flags,
  input  logic [CSEL_W-1:0]   cond_sel,
  output logic                hit
);
  logic [NUM_COND-1:0] match;

  for (genvar i = 0; i < NUM_COND; i++) begin : g_match
    assign match[i] = (cond_sel == CSEL_W'(i)) & flags[i];
  end

  assign hit = |match;
endmodule

// File: rtl/fpu_next_addr.sv
module fpu_next_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 24,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] tgt_addr
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] off_ext;

  assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign seq_addr = pc + STEP_V;
  assign tgt_addr = pc + off_ext;
endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit
  import fpu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 24,
  parameter int NUM_COND = 9,
  parameter int STEP     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CLS_W+SUB_W-1:0] opcode,
  input  logic [OFF_W-1:0]       offset,
  input  logic [NUM_COND-1:0]    flags,
  output logic [ADDR_W-1:0]      pc_q,
  output logic                   halted,
  output logic                   ret_push,
  output logic [ADDR_W-1:0]      ret_addr
);
  localparam int CSEL_W = $clog2(NUM_COND);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  act_t              act;
  logic [CSEL_W-1:0] cond_sel;
  logic              hit;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] tgt_addr;
  logic [ADDR_W-1:0] pc_d;
  logic              halt_d;
  logic              push_d;

  fpu_op_decode #(.NUM_COND(NUM_COND), .CSEL_W(CSEL_W)) dec_i (
    .opcode(opcode), .act(act), .cond_sel(cond_sel)
  );

  fpu_cond_select #(.NUM_COND(NUM_COND), .CSEL_W(CSEL_W)) cond_i (
    .flags(flags), .cond_sel(cond_sel), .hit(hit)
  );

  fpu_next_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(STEP)) addr_i (
    .pc(pc_q), .offset(offset), .seq_addr(seq_addr), .tgt_addr(tgt_addr)
  );

  always_comb begin
    pc_d   = seq_addr;
    halt_d = 1'b0;
    push_d = 1'b0;
    case (act)
      ACT_JUMP: pc_d = tgt_addr;
      ACT_COND: if (hit) pc_d = tgt_addr;
      ACT_CALL: begin
        pc_d   = tgt_addr;
        push_d = 1'b1;
      end
      ACT_HALT: begin
        pc_d   = pc_q;
        halt_d = 1'b1;
      end
      default: pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      halted   <= 1'b0;
      ret_push <= 1'b0;
      ret_addr <= '0;
    end else if (halted) begin
      ret_push <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      halted   <= halt_d;
      ret_push <= push_d;
      if (push_d) ret_addr <= seq_addr;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0) && !halted && !ret_push);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc_q) && !ret_push);

  // R7
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $stable(pc_q));

  // R9
  push_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ret_push |-> ret_addr == $past(pc_q) + STEP_V);

  // R5
  cond_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_COND && !hit && !halted) |=> pc_q == $past(pc_q) + STEP_V);
endmodule

// File: tb/flow_pc_unit_tb.sv
module flow_pc_unit_tb_top;
  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] off;
    logic [8:0]  flg;
    logic        tk;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 24'h000123, 9'h1FF, 1'b0},
    '{8'hC0, 24'h000010, 9'h000, 1'b1},
    '{8'hC0, 24'hFFFFF0, 9'h000, 1'b1},
    '{8'h20, 24'h000040, 9'h1FF, 1'b0},
    '{8'hE0, 24'h000040, 9'h1FF, 1'b0},
    '{8'hDF, 24'h000040, 9'h1FF, 1'b0},
    '{8'hCB, 24'h000040, 9'h1FF, 1'b0},
    '{8'h05, 24'h000040, 9'h1FF, 1'b0},
    '{8'h1F, 24'h000040, 9'h1FF, 1'b0},
    '{8'hC1, 24'h000100, 9'h001, 1'b1},
    '{8'hC9, 24'hFFFF00, 9'h100, 1'b1},
    '{8'hC4, 24'h000080, 9'h1F7, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic [23:0] offset = '0;
  logic [8:0]  flags = '0;
  logic [31:0] pc_q, ret_addr;
  logic        halted, ret_push;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_pc = '0;

  always #4 clk = ~clk;

  flow_pc_unit dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .offset(offset), .flags(flags),
    .pc_q(pc_q), .halted(halted), .ret_push(ret_push), .ret_addr(ret_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] op, input logic [23:0] off, input logic [8:0] flg);
    opcode = op;
    offset = off;
    flags  = flg;
    @(negedge clk);
  endtask

  function automatic logic [31:0] target(input logic [31:0] pc, input logic [23:0] off);
    return pc + {{8{off[23]}}, off};
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc after reset", pc_q, 32'h0);
    check("R1 halted after reset", {31'h0, halted}, 32'h0);
    check("R1 push after reset", {31'h0, ret_push}, 32'h0);
    rst = 1'b0;
    exp_pc = '0;

    // R2 R3 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].off, VECS[i].flg);
      exp_pc = VECS[i].tk ? target(exp_pc, VECS[i].off) : exp_pc + 32'd4;
      check($sformatf("R2/R3/R4/R5 vector %0d", i), pc_q, exp_pc);
    end

    // R5 R6: every condition, taken alone and blocked with others set
    for (int k = 0; k < 9; k++) begin
      step(8'hC1 + 8'(k), 24'h000040, 9'(1 << k));
      exp_pc = target(exp_pc, 24'h000040);
      check($sformatf("R5 cond %0d taken", k), pc_q, exp_pc);
      step(8'hC1 + 8'(k), 24'h000040, ~9'(1 << k));
      exp_pc = exp_pc + 32'd4;
      check($sformatf("R6 cond %0d others ignored", k), pc_q, exp_pc);
    end

    // R9 call
    begin
      logic [31:0] call_pc;
      call_pc = exp_pc;
      step(8'hCA, 24'h000200, 9'h000);
      exp_pc = target(call_pc, 24'h000200);
      check("R9 call target", pc_q, exp_pc);
      check("R9 push raised", {31'h0, ret_push}, 32'h1);
      check("R9 return address", ret_addr, call_pc + 32'd4);
    end
    step(8'h00, 24'h0, 9'h0);
    exp_pc = exp_pc + 32'd4;
    check("R10 push drops", {31'h0, ret_push}, 32'h0);
    check("R2 nop after call", pc_q, exp_pc);

    // R7 halt
    step(8'h01, 24'h000050, 9'h1FF);
    check("R7 pc holds on halt", pc_q, exp_pc);
    check("R7 halted set", {31'h0, halted}, 32'h1);
    // R8 ignored while halted
    step(8'hC0, 24'h001000, 9'h000);
    check("R8 jump ignored", pc_q, exp_pc);
    step(8'hCA, 24'h001000, 9'h000);
    check("R8 call ignored pc", pc_q, exp_pc);
    check("R8 call ignored push", {31'h0, ret_push}, 32'h0);
    check("R8 still halted", {31'h0, halted}, 32'h1);

    // R1 reset releases halt
    rst = 1'b1;
    step(8'h00, 24'h0, 9'h0);
    rst = 1'b0;
    check("R1 reset clears pc", pc_q, 32'h0);
    check("R1 reset clears halt", {31'h0, halted}, 32'h0);

    // R4 wrap below zero, R2 wrap through zero
    step(8'hC0, 24'hFFFFF8, 9'h000);
    check("R4 backward wrap", pc_q, 32'hFFFF_FFF8);
    step(8'h00, 24'h0, 9'h0);
    step(8'h00, 24'h0, 9'h0);
    check("R2 advance wraps to zero", pc_q, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule